// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage In-Order Pipeline

This block follows every instruction of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) and records any fault raised against it in a status vector. The vector travels with the instruction. A raised fault is not acted on at once. It is acted on only when the instruction reaches a single commit point at the end of the memory stage. Because instructions reach that point in program order, an older instruction's late fault always wins over a younger instruction's early fault.

When a faulting instruction reaches commit, the block does four things in that cycle. It pulses a flush to the fetch, decode, execute and memory stages. It keeps the faulting instruction and every younger one away from write-back. It records the restart PC and the cause code. It steers fetch to a fixed trap vector. If the faulting instruction sits in a branch delay slot, the recorded PC is that of the branch, and a flag marks the case so that the branch runs again. Further faults are ignored until a return request arrives. The return request reloads fetch with the recorded PC and leaves the exception state.

Top module: `precise_trap_unit`

## Requirements
- R1: After a synchronous active-low reset, exc_active, all flush outputs, redirect_valid and wb_valid are 0, and epc, epc_bd and cause_code are 0.
- R2: A cause pulse is collected into the status vector of the instruction that occupies the matching stage (cause_if in fetch, cause_id in decode, cause_ex in execute, cause_mem in memory). No flush or redirect happens before that instruction is in the memory stage.
- R3: Status bit positions are: bit 0 undefined instruction, bit 1 breakpoint, bit 2 system call, bit 3 arithmetic overflow, bit 4 misaligned access. The recorded cause_code is the index of the lowest set bit of the collected vector.
- R4: In the cycle a faulting instruction is in the memory stage and no exception is active, flush_if, flush_id, flush_ex and flush_mem are all 1 and redirect_valid is 1 with redirect_pc = 0x0000_0080. In the next cycle exc_active is 1.
- R5: The faulting instruction and every younger in-flight instruction never raise wb_valid. Older instructions reach write-back with their own PC on wb_pc.
- R6: epc holds the faulting instruction's PC with epc_bd = 0. If the faulting instruction was fetched right after an instruction flagged by if_branch, epc holds that PC minus 4 and epc_bd = 1.
- R7: Faults are ordered by age. An older instruction's memory-stage fault is taken even when a younger instruction raised its fault earlier in time, and the younger one is flushed.
- R8: While exc_active is 1, cause pulses cause no flush, instructions carrying causes still reach write-back, and epc, epc_bd and cause_code keep their values.
- R9: ret_req while exc_active is 1 gives redirect_valid = 1 with redirect_pc = epc in that cycle, and exc_active becomes 0 in the next cycle. ret_req while exc_active is 0 has no effect on redirect_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | A valid instruction is fetched this cycle |
| if_pc | input | 32 | PC of the fetched instruction |
| if_branch | input | 1 | The fetched instruction is a delayed branch |
| cause_if | input | 5 | Cause pulses against the instruction in fetch |
| cause_id | input | 5 | Cause pulses against the instruction in decode |
| cause_ex | input | 5 | Cause pulses against the instruction in execute |
| cause_mem | input | 5 | Cause pulses against the instruction in memory |
| ret_req | input | 1 | Return from the exception handler |
| flush_if | output | 1 | Kill the fetch stage |
| flush_id | output | 1 | Kill the decode stage |
| flush_ex | output | 1 | Kill the execute stage |
| flush_mem | output | 1 | Kill the memory stage |
| redirect_valid | output | 1 | Load fetch with redirect_pc |
| redirect_pc | output | 32 | Trap vector or restart PC |
| epc | output | 32 | Recorded restart PC |
| epc_bd | output | 1 | Recorded fault was in a delay slot |
| cause_code | output | 3 | Recorded cause code |
| exc_active | output | 1 | An exception is being handled |
| wb_valid | output | 1 | An instruction is writing back this cycle |
| wb_pc | output | 32 | PC of the instruction in write-back |

## Verification
The assertions check on every cycle several things. A take is followed by exc_active and by an empty write-back slot, and a flush empties every stage slot. A return clears the active state. The recorded PC and cause stay still while an exception is active, and the cause code stays inside its range. Only the bench scenarios can show the rest, because it depends on stimulus history. These are the lowest-bit cause choice for every cause mask, the take cycle for every stage in which a fault can be raised, the branch-minus-four restart for delay slots, the age ordering between a load and the instruction behind it, and the restart PC returned on the redirect.

// File: rtl/ptu_pkg.sv
// Shared widths, cause bit positions and the stage slot record for the
// precise trap unit. Assumes 32-bit PCs and five cause bits.
package ptu_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned NCAUSE = 5;
    localparam int unsigned CODE_W = $clog2(NCAUSE);

    // Cause bit positions; lower index wins inside one instruction.
    localparam int unsigned CB_UNDEF = 0;
    localparam int unsigned CB_BRK   = 1;
    localparam int unsigned CB_SYS   = 2;
    localparam int unsigned CB_OVF   = 3;
    localparam int unsigned CB_ALIGN = 4;

    // One in-flight instruction as seen by the trap logic.
    typedef struct packed {
        logic              valid;
        logic              bd;
        logic [XLEN-1:0]   pc;
        logic [NCAUSE-1:0] status;
    } slot_t;
endpackage

// File: rtl/ptu_slot.sv
// One pipeline stage slot. It holds an instruction's PC, delay-slot flag
// and status vector. The stage's cause pulse is merged into the vector
// combinationally. A flush empties the slot at the next edge.
// Assumes the pipeline advances every cycle.
module ptu_slot
    import ptu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  slot_t             d,
    input  logic [NCAUSE-1:0] cause,
    output slot_t             q_full
);
    slot_t q;

    // Capture the older stage's record, or empty the slot on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) q <= '0;
        else                 q <= d;
    end

    // Merge this stage's cause pulse into the held status vector.
    always_comb begin
        q_full        = q;
        q_full.status = q.status | (q.valid ? cause : '0);
    end

    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q.valid);
endmodule

// File: rtl/ptu_prio_enc.sv
// Lowest-index-wins priority encoder over a cause vector.
// Assumes W bits are enough to hold N-1.
module ptu_prio_enc #(
    parameter int unsigned N = 5,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] code
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) code = W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/ptu_commit.sv
// Commit-point controller. It decides whether the memory-stage
// instruction takes an exception and records the restart PC, the
// delay-slot flag and the cause. It also tracks the active state and
// drives the fetch redirect for a take or a return.
// Assumes the delay-slot instruction sits PC_STEP after its branch.
module ptu_commit
    import ptu_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_0080,
    parameter logic [XLEN-1:0] PC_STEP  = 32'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             mem,
    input  logic              ret_req,
    output logic              take,
    output logic              ret_fire,
    output logic              active,
    output logic [XLEN-1:0]   epc,
    output logic              epc_bd,
    output logic [CODE_W-1:0] cause_code,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    logic              any_cause;
    logic [CODE_W-1:0] code_now;

    ptu_prio_enc #(.N(NCAUSE), .W(CODE_W)) u_enc (
        .vec  (mem.status),
        .any  (any_cause),
        .code (code_now)
    );

    // Take and return decisions for this cycle.
    always_comb begin
        take     = mem.valid && any_cause && !active;
        ret_fire = ret_req && active;
    end

    // Steer fetch to the trap vector on a take, or to the restart PC on a return.
    always_comb begin
        redirect_valid = take || ret_fire;
        redirect_pc    = take ? TRAP_VEC : epc;
    end

    // Enter the active state on a take and leave it on a return.
    always_ff @(posedge clk) begin
        if (!rst_n)        active <= 1'b0;
        else if (take)     active <= 1'b1;
        else if (ret_fire) active <= 1'b0;
    end

    // Record the restart PC, the delay-slot flag and the cause on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc        <= '0;
            epc_bd     <= 1'b0;
            cause_code <= '0;
        end else if (take) begin
            epc        <= mem.bd ? (mem.pc - PC_STEP) : mem.pc;
            epc_bd     <= mem.bd;
            cause_code <= code_now;
        end
    end

    p_take_sets_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> active);
    p_ret_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> !active);
    p_hold_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ret_req) |=> ($stable(epc) && $stable(epc_bd) && $stable(cause_code)));
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cause_code) < NCAUSE);
endmodule

// File: rtl/precise_trap_unit.sv
// Precise exception controller for a five-stage in-order pipeline.
// It tags each fetched instruction with a delay-slot flag and a status
// vector and carries them through decode, execute and memory. Exceptions
// are acted on only at the memory-stage commit point. A take flushes every
// stage and blocks the faulting instruction from write-back.
// Assumes the pipeline advances one stage every cycle.
module precise_trap_unit
    import ptu_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_0080,
    parameter logic [XLEN-1:0] PC_STEP  = 32'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic [XLEN-1:0]   if_pc,
    input  logic              if_branch,
    input  logic [NCAUSE-1:0] cause_if,
    input  logic [NCAUSE-1:0] cause_id,
    input  logic [NCAUSE-1:0] cause_ex,
    input  logic [NCAUSE-1:0] cause_mem,
    input  logic              ret_req,
    output logic              flush_if,
    output logic              flush_id,
    output logic              flush_ex,
    output logic              flush_mem,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   epc,
    output logic              epc_bd,
    output logic [CODE_W-1:0] cause_code,
    output logic              exc_active,
    output logic              wb_valid,
    output logic [XLEN-1:0]   wb_pc
);
    localparam int unsigned NSLOT = 3;  // decode, execute, memory

    logic              take;
    logic              ret_fire;
    logic              bd_pending;
    slot_t             if_slot;
    slot_t             slot_d    [NSLOT];
    slot_t             slot_full [NSLOT];
    logic [NCAUSE-1:0] stage_cause [NSLOT];

    // Remember whether the last valid fetch was a delayed branch.
    always_ff @(posedge clk) begin
        if (!rst_n || take) bd_pending <= 1'b0;
        else if (if_valid)  bd_pending <= if_branch;
    end

    // Build the fetch-stage record, including fetch-time causes.
    always_comb begin
        if_slot.valid  = if_valid;
        if_slot.bd     = if_valid && bd_pending;
        if_slot.pc     = if_pc;
        if_slot.status = if_valid ? cause_if : '0;
    end

    // Map the per-stage cause ports onto the slot chain.
    always_comb begin
        stage_cause[0] = cause_id;
        stage_cause[1] = cause_ex;
        stage_cause[2] = cause_mem;
    end

    genvar k;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_slot
            if (k == 0) begin : g_head
                assign slot_d[k] = if_slot;
            end else begin : g_link
                assign slot_d[k] = slot_full[k-1];
            end
            ptu_slot u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .flush  (take),
                .d      (slot_d[k]),
                .cause  (stage_cause[k]),
                .q_full (slot_full[k])
            );
        end
    endgenerate

    ptu_commit #(.TRAP_VEC(TRAP_VEC), .PC_STEP(PC_STEP)) u_commit (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem            (slot_full[NSLOT-1]),
        .ret_req        (ret_req),
        .take           (take),
        .ret_fire       (ret_fire),
        .active         (exc_active),
        .epc            (epc),
        .epc_bd         (epc_bd),
        .cause_code     (cause_code),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    // Pass the committing instruction to write-back unless it faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_pc    <= '0;
        end else begin
            wb_valid <= slot_full[NSLOT-1].valid && !take;
            wb_pc    <= slot_full[NSLOT-1].pc;
        end
    end

    // All stage kills share the commit decision.
    always_comb begin
        flush_if  = take;
        flush_id  = take;
        flush_ex  = take;
        flush_mem = take;
    end

    p_faulter_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !wb_valid);
    p_ret_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && exc_active) |-> (redirect_valid && redirect_pc == epc));
endmodule

// File: tb/precise_trap_unit_test.sv
// Self-checking bench: sweeps every cause mask against every raising stage,
// with and without a delay slot, and adds ordering, hold-off and return cases.
module precise_trap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_valid, if_branch, ret_req;
    logic [31:0] if_pc;
    logic [4:0]  cause_if, cause_id, cause_ex, cause_mem;
    logic        flush_if, flush_id, flush_ex, flush_mem;
    logic        redirect_valid, epc_bd, exc_active, wb_valid;
    logic [31:0] redirect_pc, epc, wb_pc;
    logic [2:0]  cause_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    precise_trap_unit uut (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
        .if_branch(if_branch), .cause_if(cause_if), .cause_id(cause_id),
        .cause_ex(cause_ex), .cause_mem(cause_mem), .ret_req(ret_req),
        .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
        .flush_mem(flush_mem), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .epc(epc), .epc_bd(epc_bd),
        .cause_code(cause_code), .exc_active(exc_active),
        .wb_valid(wb_valid), .wb_pc(wb_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start a cycle: inputs change 2 ns after the edge, checks follow 8 ns later.
    task automatic cyc_start();
        @(posedge clk);
        #2;
        if_valid = 0; if_branch = 0; if_pc = 0; ret_req = 0;
        cause_if = 0; cause_id = 0; cause_ex = 0; cause_mem = 0;
    endtask

    function automatic logic [2:0] low_bit(input logic [4:0] m);
        logic [2:0] r = 0;
        for (int i = 4; i >= 0; i--) if (m[i]) r = 3'(i);
        return r;
    endfunction

    // Leave the active state with a return and check the restart redirect.
    task automatic do_return(input logic [31:0] exp_pc);
        cyc_start();
        ret_req = 1;
        #8;
        chk(redirect_valid === 1'b1, "R9 return redirect", {31'd0, redirect_valid}, 32'd1);
        chk(redirect_pc === exp_pc, "R9 return pc", redirect_pc, exp_pc);
        cyc_start();
        #8;
        chk(exc_active === 1'b0, "R9 active cleared", {31'd0, exc_active}, 32'd0);
    endtask

    // I0 at cycle 0 (branch if ds), faulter I1 at cycle 1, mask raised in stage stg.
    task automatic run_case(input logic [4:0] mask, input int stg, input bit ds, input logic [31:0] base);
        logic [31:0] exp_epc;
        exp_epc = ds ? base : base + 32'd4;
        for (int c = 0; c <= 4; c++) begin
            cyc_start();
            if_valid = 1;
            if_pc = base + 32'(4 * c);
            if_branch = (c == 0) && ds;
            if (c == 1 + stg) begin
                case (stg)
                    0: cause_if  = mask;
                    1: cause_id  = mask;
                    2: cause_ex  = mask;
                    default: cause_mem = mask;
                endcase
            end
            #8;
            if (c < 4) begin
                chk(flush_mem === 1'b0 && redirect_valid === 1'b0, "R2 no early take",
                    {31'd0, flush_mem}, 32'd0);
            end else begin
                chk(flush_if && flush_id && flush_ex && flush_mem, "R4 flush all",
                    {28'd0, flush_if, flush_id, flush_ex, flush_mem}, 32'hf);
                chk(redirect_valid === 1'b1 && redirect_pc === 32'h80, "R4 trap vector",
                    redirect_pc, 32'h80);
                chk(wb_valid === 1'b1 && wb_pc === base, "R5 older completes", wb_pc, base);
            end
        end
        for (int c = 5; c <= 8; c++) begin
            cyc_start();
            #8;
            chk(wb_valid === 1'b0, "R5 faulter and younger blocked", {31'd0, wb_valid}, 32'd0);
            if (c == 5) begin
                chk(exc_active === 1'b1, "R4 active after take", {31'd0, exc_active}, 32'd1);
                chk(epc === exp_epc, "R6 epc", epc, exp_epc);
                chk(epc_bd === ds, "R6 delay-slot flag", {31'd0, epc_bd}, {31'd0, ds});
                chk(cause_code === low_bit(mask), "R3 cause code", {29'd0, cause_code},
                    {29'd0, low_bit(mask)});
            end
        end
        do_return(exp_epc);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        rst_n = 0;
        if_valid = 0; if_branch = 0; if_pc = 0; ret_req = 0;
        cause_if = 0; cause_id = 0; cause_ex = 0; cause_mem = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        #8;
        chk(exc_active === 0 && wb_valid === 0 && redirect_valid === 0 && flush_if === 0,
            "R1 reset controls", {28'd0, exc_active, wb_valid, redirect_valid, flush_if}, 32'd0);
        chk(epc === 0 && epc_bd === 0 && cause_code === 0, "R1 reset record", epc, 32'd0);

        // R9: a return with no active exception does nothing.
        cyc_start();
        ret_req = 1;
        #8;
        chk(redirect_valid === 1'b0, "R9 return ignored when idle", {31'd0, redirect_valid}, 32'd0);

        // Sweep all masks, stages and delay-slot choices (R2 R3 R4 R5 R6).
        base = 32'h0000_1000;
        for (int m = 1; m < 32; m++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 2; d++) begin
                    run_case(5'(m), s, d[0], base);
                    base = base + 32'h40;
                end

        // R7: the younger I1 raises undefined in fetch at cycle 1, and the
        // older I0 raises misaligned in memory at cycle 3. I0 must win.
        base = 32'h0000_9000;
        for (int c = 0; c <= 3; c++) begin
            cyc_start();
            if_valid = 1;
            if_pc = base + 32'(4 * c);
            if (c == 1) cause_if = 5'b00001;
            if (c == 3) cause_mem = 5'b10000;
            #8;
            if (c == 3)
                chk(flush_mem === 1'b1, "R7 older fault taken first", {31'd0, flush_mem}, 32'd1);
        end
        for (int c = 4; c <= 7; c++) begin
            cyc_start();
            #8;
            chk(wb_valid === 1'b0 && flush_mem === 1'b0, "R7 younger flushed",
                {31'd0, wb_valid}, 32'd0);
            if (c == 4) begin
                chk(epc === base, "R7 epc is older instruction", epc, base);
                chk(cause_code === 3'd4, "R7 cause misaligned", {29'd0, cause_code}, 32'd4);
            end
        end

        // R8: causes during handling are ignored and the record holds.
        for (int c = 0; c < 8; c++) begin
            cyc_start();
            if_valid = 1;
            if_pc = 32'h80 + 32'(4 * c);
            cause_if = 5'h1f;
            cause_ex = 5'h08;
            cause_mem = 5'h10;
            #8;
            chk(flush_mem === 1'b0 && redirect_valid === 1'b0, "R8 no take while active",
                {31'd0, flush_mem}, 32'd0);
            chk(epc === base && cause_code === 3'd4, "R8 record held", epc, base);
            if (c >= 4)
                chk(wb_valid === 1'b1 && wb_pc === 32'h80 + 32'(4 * (c - 4)),
                    "R8 handler instructions retire", wb_pc, 32'h80 + 32'(4 * (c - 4)));
        end
        do_return(base);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule